// File: doc/BRIEF.md
# Synchronous Burst SRAM Model

This block is a synthesizable single-port synchronous SRAM. It stores 36-bit words made of four 9-bit byte lanes and has a small depth that is set by a parameter. Every command is registered on the rising clock edge: the address, three chip selects, two start strobes, a burst-advance input and the write controls. Once a start has opened an access, an internal 2-bit counter steps through the four words of an aligned group. The counter follows either a linear order or an interleaved (XOR) order. A system can therefore stream four words from a single address, or give a new address on every cycle.

The read side has two timing options, chosen by a static mode input. With the flow-through option, read data comes from the array directly after the edge that captured the command. With the pipelined option, the data passes through one more output register. The tri-state data pins are modelled as a `rdata` bus and a `rvalid` flag. The flag is low whenever the output would be high-impedance. Output enable and sleep act on the outputs with no clock edge involved. Sleep also ends any open burst and blocks commands, and the stored words are kept.

Writes can update single lanes through a byte-write enable and per-lane selects. A global write updates the whole word, and it takes precedence over the lane controls.

Top module: `burst_sram`

## Requirements
- R1: An access opens only when a start strobe is sampled low while `cs_a_n`=0, `cs_b`=1 and `cs_c_n`=0. A strobe sampled with any of the three selects inactive is a deselect: it writes nothing and it ends the open burst.
- R2: A start from `host_start_n` is always a read, and the write controls sampled with it are ignored. A start from `ctl_start_n` alone obeys the write controls. When both strobes are low, `host_start_n` wins.
- R3: On a cycle with no strobe inside an open burst, `burst_adv_n`=0 steps the 2-bit counter and `burst_adv_n`=1 holds it. The two low address bits are (start + count) mod 4 when `lin_order`=1, and start XOR count when `lin_order`=0. The upper address bits stay fixed. Cycles that continue a burst obey the write controls.
- R4: When `bw_en_n`=0, lane i (bits 9i+8..9i) is written only when `lane_sel_n[i]`=0, and all other lanes keep their contents. A write cycle with no lane selected acts as a read.
- R5: When `all_wr_n`=0, all four lanes are written, whatever `bw_en_n` and `lane_sel_n` are.
- R6: With `pipe_mode`=0, the data of a read captured on edge k appears on `rdata` with `rvalid`=1 right after edge k. A first access therefore takes two clocks and each following word takes one.
- R7: With `pipe_mode`=1, the same data appears right after edge k+1. A first access therefore takes three clocks and each following word takes one.
- R8: After a deselect captured on edge k, `rvalid` is low from edge k onward in flow-through mode and from edge k+1 onward in pipelined mode. It stays low until a new start. After reset, `rvalid` is 0.
- R9: `out_en_n`=1 forces `rvalid`=0 and `rdata`=0 at once, with no clock edge, and it leaves the access and the counter undisturbed.
- R10: `sleep`=1 forces `rvalid`=0 at once. Each edge that samples sleep high ignores all commands and closes the burst. Stored words are kept.
- R11: A cycle that writes drives no output: `rvalid` is 0 after a write captured in flow-through mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Word address sampled at a start |
| cs_a_n | input | 1 | Chip select, active low |
| cs_b | input | 1 | Chip select, active high |
| cs_c_n | input | 1 | Chip select, active low |
| host_start_n | input | 1 | Read-only start strobe, active low |
| ctl_start_n | input | 1 | Read/write start strobe, active low |
| burst_adv_n | input | 1 | Step burst counter, active low |
| bw_en_n | input | 1 | Byte-write enable, active low |
| lane_sel_n | input | LANES | Per-lane write select, active low |
| all_wr_n | input | 1 | Global write, active low |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Asynchronous sleep, active high |
| pipe_mode | input | 1 | 1 = pipelined reads, 0 = flow-through |
| lin_order | input | 1 | 1 = linear burst order, 0 = interleaved |
| wdata | input | LANES*LANE_W | Write data |
| rdata | output | LANES*LANE_W | Read data, zero when not valid |
| rvalid | output | 1 | Output driven (low models high-impedance) |

## Verification
Directed bursts cover four cases: a linear burst that starts mid-group and wraps, an interleaved burst from an odd start, a read that gets cut off by a deselect, and reads interrupted by output-enable and sleep. These cases separate the two counting orders and the deselect timing of the two output modes. Further directed writes use a lane pattern with gaps, and they combine global write with lane selects and with the read-only strobe. Each pattern gives a different word, so byte masking, global precedence and strobe priority can each be told apart. Random traffic is then run in every combination of output mode and burst order. It mixes strobes, disabled selects, partial writes, advance and hold, and short sleep and output-enable pulses. Its results are compared against a reference word array in the bench.

// File: rtl/bsram_pkg.sv
package bsram_pkg;

    // Width of the in-burst counter (four-word groups)
    localparam int BURST_BITS = 2;

    // Low address bits of the current beat of a burst
    function automatic logic [BURST_BITS-1:0] burst_offset(
        input logic [BURST_BITS-1:0] start,
        input logic [BURST_BITS-1:0] count,
        input logic                  linear
    );
        logic [BURST_BITS-1:0] sum;
        sum = start + count;
        return linear ? sum : (start ^ count);
    endfunction

endpackage

// File: rtl/bsram_wmask.sv
module bsram_wmask #(
    parameter int LANES = 4
) (
    input  logic             all_wr_n,
    input  logic             bw_en_n,
    input  logic [LANES-1:0] lane_sel_n,
    output logic [LANES-1:0] mask
);

    always_comb begin
        if (!all_wr_n) begin
            mask = '1;
        end else if (!bw_en_n) begin
            mask = ~lane_sel_n;
        end else begin
            mask = '0;
        end
    end

endmodule

// File: rtl/bsram_array.sv
module bsram_array #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic [LANES-1:0]        we,
    input  logic [ADDR_W-1:0]       waddr,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic [ADDR_W-1:0]       raddr,
    output logic [LANES*LANE_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [LANE_W-1:0] lane_mem [DEPTH];

        always_ff @(posedge clk) begin
            if (we[l]) begin
                lane_mem[waddr] <= wdata[l*LANE_W +: LANE_W];
            end
        end

        assign rdata[l*LANE_W +: LANE_W] = lane_mem[raddr];
    end

endmodule

// File: rtl/burst_sram.sv
module burst_sram #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    cs_a_n,
    input  logic                    cs_b,
    input  logic                    cs_c_n,
    input  logic                    host_start_n,
    input  logic                    ctl_start_n,
    input  logic                    burst_adv_n,
    input  logic                    bw_en_n,
    input  logic [LANES-1:0]        lane_sel_n,
    input  logic                    all_wr_n,
    input  logic                    out_en_n,
    input  logic                    sleep,
    input  logic                    pipe_mode,
    input  logic                    lin_order,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] rdata,
    output logic                    rvalid
);
    import bsram_pkg::*;

    localparam int DW = LANES * LANE_W;
    localparam int BB = BURST_BITS;

    typedef struct packed {
        logic              active;
        logic [ADDR_W-1:0] base;
        logic [BB-1:0]     cnt;
        logic [ADDR_W-1:0] acc;
        logic              rd;
        logic              pv;
        logic [DW-1:0]     pd;
    } state_t;

    state_t st_d, st_q;

    logic [LANES-1:0] dec_mask;
    logic [LANES-1:0] wmask;
    logic [DW-1:0]    arr_rdata;
    logic             sel_ok;
    logic             strobe;
    logic             go;
    logic             wr_ok;

    bsram_wmask #(.LANES(LANES)) wmask_i (
        .all_wr_n   (all_wr_n),
        .bw_en_n    (bw_en_n),
        .lane_sel_n (lane_sel_n),
        .mask       (dec_mask)
    );

    bsram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) array_i (
        .clk   (clk),
        .we    (wmask),
        .waddr (st_d.acc),
        .wdata (wdata),
        .raddr (st_q.acc),
        .rdata (arr_rdata)
    );

    always_comb begin
        sel_ok  = !cs_a_n && cs_b && !cs_c_n;
        strobe  = !host_start_n || !ctl_start_n;
        go      = 1'b0;
        wr_ok   = 1'b0;
        st_d    = st_q;
        st_d.pv = st_q.rd;
        st_d.pd = arr_rdata;

        if (sleep) begin
            st_d.active = 1'b0;
        end else if (strobe) begin
            if (sel_ok) begin
                st_d.active = 1'b1;
                st_d.base   = addr;
                st_d.cnt    = '0;
                go          = 1'b1;
                wr_ok       = host_start_n;
            end else begin
                st_d.active = 1'b0;
            end
        end else if (st_q.active) begin
            if (!burst_adv_n) begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
            go    = 1'b1;
            wr_ok = 1'b1;
        end

        st_d.acc = {st_d.base[ADDR_W-1:BB],
                    burst_offset(st_d.base[BB-1:0], st_d.cnt, lin_order)};
        wmask    = (go && wr_ok) ? dec_mask : '0;
        st_d.rd  = go && (wmask == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rvalid = (pipe_mode ? st_q.pv : st_q.rd) && !out_en_n && !sleep;
        rdata  = rvalid ? (pipe_mode ? st_q.pd : arr_rdata) : '0;
    end

endmodule

// File: rtl/burst_sram_chk.sv
module burst_sram_chk #(
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    cs_a_n,
    input logic                    cs_b,
    input logic                    cs_c_n,
    input logic                    host_start_n,
    input logic                    ctl_start_n,
    input logic                    bw_en_n,
    input logic [LANES-1:0]        lane_sel_n,
    input logic                    all_wr_n,
    input logic                    out_en_n,
    input logic                    sleep,
    input logic                    pipe_mode,
    input logic [LANES*LANE_W-1:0] rdata,
    input logic                    rvalid,
    input logic [LANES-1:0]        wmask
);

    logic       sel_ok, strobe, rd_start, dsel;
    logic [1:0] cyc;

    assign sel_ok   = !cs_a_n && cs_b && !cs_c_n;
    assign strobe   = !host_start_n || !ctl_start_n;
    assign rd_start = !host_start_n && sel_ok && !sleep;
    assign dsel     = strobe && !sel_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc <= '0;
        end else if (cyc != 2'd3) begin
            cyc <= cyc + 2'd1;
        end
    end

    a_r2_host_start_reads: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_start_n && sel_ok) |-> (wmask == '0));

    a_r4_unselected_kept: assert property (@(posedge clk) disable iff (!rst_n)
        all_wr_n |-> ((wmask & lane_sel_n) == '0));

    a_r4_no_enable_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (all_wr_n && bw_en_n) |-> (wmask == '0));

    a_r5_global_all_lanes: assert property (@(posedge clk) disable iff (!rst_n)
        (!all_wr_n && !ctl_start_n && host_start_n && sel_ok && !sleep) |-> (wmask == '1));

    a_r6_flow_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (!pipe_mode && rd_start) |=> (rvalid || out_en_n || sleep || pipe_mode));

    a_r7_pipe_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc == 2'd3 && pipe_mode && $past(pipe_mode) && $past(rd_start, 2))
            |-> (rvalid || out_en_n || sleep));

    a_r8_flow_deselect: assert property (@(posedge clk) disable iff (!rst_n)
        (!pipe_mode && dsel) |=> (!rvalid || pipe_mode));

    a_r8_pipe_deselect: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc == 2'd3 && pipe_mode && $past(pipe_mode) && $past(dsel, 2)) |-> !rvalid);

    a_r9_oe_off: assert property (@(posedge clk) disable iff (!rst_n)
        out_en_n |-> (!rvalid && rdata == '0));

    a_r10_sleep_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> (!rvalid && wmask == '0));

endmodule

bind burst_sram burst_sram_chk #(.LANES(LANES), .LANE_W(LANE_W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .cs_a_n       (cs_a_n),
    .cs_b         (cs_b),
    .cs_c_n       (cs_c_n),
    .host_start_n (host_start_n),
    .ctl_start_n  (ctl_start_n),
    .bw_en_n      (bw_en_n),
    .lane_sel_n   (lane_sel_n),
    .all_wr_n     (all_wr_n),
    .out_en_n     (out_en_n),
    .sleep        (sleep),
    .pipe_mode    (pipe_mode),
    .rdata        (rdata),
    .rvalid       (rvalid),
    .wmask        (wmask)
);

// File: tb/burst_sram_tb_top.sv
`timescale 1ns/1ps
module burst_sram_tb_top;

    localparam int AW = 6;
    localparam int NL = 4;
    localparam int LW = 9;
    localparam int DW = NL * LW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          cs_a_n = 1'b0, cs_b = 1'b1, cs_c_n = 1'b0;
    logic          host_start_n = 1'b1, ctl_start_n = 1'b1, burst_adv_n = 1'b1;
    logic          bw_en_n = 1'b1, all_wr_n = 1'b1;
    logic [NL-1:0] lane_sel_n = '1;
    logic          out_en_n = 1'b0, sleep = 1'b0;
    logic          pipe_mode = 1'b0, lin_order = 1'b1;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          rvalid;

    always #4 clk = ~clk;

    burst_sram #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW)) dut_i (
        .clk(clk), .rst_n(rst_n), .addr(addr),
        .cs_a_n(cs_a_n), .cs_b(cs_b), .cs_c_n(cs_c_n),
        .host_start_n(host_start_n), .ctl_start_n(ctl_start_n),
        .burst_adv_n(burst_adv_n), .bw_en_n(bw_en_n),
        .lane_sel_n(lane_sel_n), .all_wr_n(all_wr_n),
        .out_en_n(out_en_n), .sleep(sleep), .pipe_mode(pipe_mode),
        .lin_order(lin_order), .wdata(wdata), .rdata(rdata), .rvalid(rvalid)
    );

    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 0;
    string tag = "R8";

    // reference model state
    logic [DW-1:0] ref_mem [1 << AW];
    bit            m_act = 0;
    logic [AW-1:0] m_base = '0;
    logic [1:0]    m_cnt = '0;
    bit            e1v = 0, e2v = 0;
    logic [DW-1:0] e1d = '0, e2d = '0;

    function automatic logic [DW-1:0] pat(input int a);
        return {6'(a), 30'(a * 1237 + 30'h1357)};
    endfunction

    function automatic logic [AW-1:0] beat_addr(input logic [AW-1:0] b, input logic [1:0] c,
                                                input bit lin);
        logic [1:0] lo;
        lo = lin ? 2'(b[1:0] + c) : (b[1:0] ^ c);
        return {b[AW-1:2], lo};
    endfunction

    function automatic logic [NL-1:0] ref_mask();
        if (!all_wr_n) return '1;
        if (!bw_en_n) return ~lane_sel_n;
        return '0;
    endfunction

    task automatic chk(input bit ok, input string t, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", t, what, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    task automatic model_edge();
        bit            sel, go, wok, rd;
        logic [NL-1:0] mk;
        logic [AW-1:0] a;
        logic [DW-1:0] d;
        sel = !cs_a_n && cs_b && !cs_c_n;
        go = 0; wok = 0; rd = 0; d = '0;
        if (sleep) begin
            m_act = 0;
        end else if (!host_start_n || !ctl_start_n) begin
            if (sel) begin
                m_act = 1; m_base = addr; m_cnt = 0; go = 1; wok = host_start_n;
            end else begin
                m_act = 0;
            end
        end else if (m_act) begin
            if (!burst_adv_n) m_cnt = m_cnt + 2'd1;
            go = 1; wok = 1;
        end
        if (go) begin
            a  = beat_addr(m_base, m_cnt, lin_order);
            mk = wok ? ref_mask() : '0;
            if (mk == '0) begin
                rd = 1; d = ref_mem[a];
            end else begin
                for (int l = 0; l < NL; l++)
                    if (mk[l]) ref_mem[a][l*LW +: LW] = wdata[l*LW +: LW];
            end
        end
        e2v = e1v; e2d = e1d;
        e1v = rd;  e1d = d;
    endtask

    task automatic tick();
        bit            ev;
        logic [DW-1:0] ed;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        ev = (pipe_mode ? e2v : e1v) && !out_en_n && !sleep;
        ed = ev ? (pipe_mode ? e2d : e1d) : '0;
        chk(rvalid === ev, tag, "rvalid", 64'(rvalid), 64'(ev));
        chk(rdata === ed, tag, "rdata", 64'(rdata), 64'(ed));
    endtask

    task automatic idle();
        host_start_n = 1; ctl_start_n = 1; burst_adv_n = 1;
        bw_en_n = 1; all_wr_n = 1; lane_sel_n = '1;
        cs_a_n = 0; cs_b = 1; cs_c_n = 0;
    endtask

    task automatic dsel();
        idle(); ctl_start_n = 0; cs_b = 0; tick(); idle();
    endtask

    task automatic start_rd(input int a);
        idle(); host_start_n = 0; addr = AW'(a); tick(); idle();
    endtask

    task automatic start_wr(input int a, input logic [DW-1:0] d, input bit gw,
                            input logic [NL-1:0] sel_n);
        idle(); ctl_start_n = 0; addr = AW'(a); wdata = d;
        if (gw) all_wr_n = 0; else begin bw_en_n = 0; lane_sel_n = sel_n; end
        tick(); idle();
    endtask

    task automatic adv_rd();
        idle(); burst_adv_n = 0; tick(); idle();
    endtask

    task automatic adv_wr(input logic [DW-1:0] d);
        idle(); burst_adv_n = 0; all_wr_n = 0; wdata = d; tick(); idle();
    endtask

    initial begin
        #800000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        logic [DW-1:0] w, junk, expw;
        void'($urandom(32'h5eed_0042));
        for (int i = 0; i < (1 << AW); i++) ref_mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R8: quiet after reset
        chk(rvalid === 1'b0, "R8", "reset rvalid", 64'(rvalid), 64'd0);
        chk(rdata === '0, "R8", "reset rdata", 64'(rdata), 64'd0);

        // R5: fill array with global-write bursts
        tag = "R5";
        for (int b = 0; b < (1 << AW) / 4; b++) begin
            start_wr(b * 4, pat(b * 4), 1, '1);
            for (int k = 1; k < 4; k++) adv_wr(pat(b * 4 + k));
        end
        dsel(); dsel();

        // R3/R6: linear burst from mid-group wraps
        tag = "R3"; lin_order = 1;
        start_rd(6);
        chk(rvalid === 1'b1, "R6", "flow first beat valid", 64'(rvalid), 64'd1);
        chk(rdata === pat(6), "R3", "linear beat0", 64'(rdata), 64'(pat(6)));
        adv_rd(); chk(rdata === pat(7), "R3", "linear beat1", 64'(rdata), 64'(pat(7)));
        adv_rd(); chk(rdata === pat(4), "R3", "linear beat2", 64'(rdata), 64'(pat(4)));
        adv_rd(); chk(rdata === pat(5), "R3", "linear beat3", 64'(rdata), 64'(pat(5)));
        idle(); tick(); chk(rdata === pat(5), "R3", "hold beat", 64'(rdata), 64'(pat(5)));
        dsel();

        // R3: interleaved order from odd start
        lin_order = 0;
        start_rd(9);  chk(rdata === pat(9),  "R3", "ileave beat0", 64'(rdata), 64'(pat(9)));
        adv_rd();     chk(rdata === pat(8),  "R3", "ileave beat1", 64'(rdata), 64'(pat(8)));
        adv_rd();     chk(rdata === pat(11), "R3", "ileave beat2", 64'(rdata), 64'(pat(11)));
        adv_rd();     chk(rdata === pat(10), "R3", "ileave beat3", 64'(rdata), 64'(pat(10)));
        dsel(); lin_order = 1;

        // R2: host strobe ignores write controls and wins over controller strobe
        tag = "R2"; junk = 36'h0_DEAD_BEEF;
        idle(); host_start_n = 0; ctl_start_n = 0; all_wr_n = 0; wdata = junk; addr = 20;
        tick(); idle();
        chk(rvalid === 1'b1 && rdata === pat(20), "R2", "host start reads", 64'(rdata), 64'(pat(20)));
        dsel();
        start_rd(20); chk(rdata === pat(20), "R2", "word unchanged", 64'(rdata), 64'(pat(20)));
        dsel();

        // R4/R11: partial lane write
        tag = "R4"; w = 36'hA_5A5A_5A5A;
        start_wr(21, w, 0, 4'b1010);
        chk(rvalid === 1'b0, "R11", "write drives nothing", 64'(rvalid), 64'd0);
        dsel();
        expw = {pat(21)[35:27], w[26:18], pat(21)[17:9], w[8:0]};
        start_rd(21); chk(rdata === expw, "R4", "lanes 0,2 only", 64'(rdata), 64'(expw));
        dsel();
        start_wr(22, w, 0, 4'b1111);
        chk(rvalid === 1'b1 && rdata === pat(22), "R4", "no lane acts as read", 64'(rdata), 64'(pat(22)));
        dsel();

        // R5: global write overrides lane selects
        tag = "R5"; w = 36'h3_1234_5678;
        idle(); ctl_start_n = 0; all_wr_n = 0; bw_en_n = 0; lane_sel_n = 4'b1110;
        addr = 23; wdata = w; tick(); idle();
        dsel();
        start_rd(23); chk(rdata === w, "R5", "global whole word", 64'(rdata), 64'(w));
        dsel();

        // R1: each select inactive blocks the access
        tag = "R1";
        for (int v = 0; v < 3; v++) begin
            idle(); ctl_start_n = 0; all_wr_n = 0; wdata = junk; addr = 24;
            if (v == 0) cs_a_n = 1; else if (v == 1) cs_b = 0; else cs_c_n = 1;
            tick(); idle();
            chk(rvalid === 1'b0, "R1", "disabled start", 64'(rvalid), 64'd0);
            adv_rd();
            chk(rvalid === 1'b0, "R1", "no burst opened", 64'(rvalid), 64'd0);
        end
        start_rd(24); chk(rdata === pat(24), "R1", "no write when disabled", 64'(rdata), 64'(pat(24)));
        dsel();

        // R8: flow-through deselect cuts output at once
        tag = "R8";
        start_rd(28); adv_rd();
        dsel(); chk(rvalid === 1'b0, "R8", "flow off after deselect", 64'(rvalid), 64'd0);
        adv_rd(); chk(rvalid === 1'b0, "R8", "stays off", 64'(rvalid), 64'd0);

        // R9: output enable is asynchronous and keeps the burst
        tag = "R9";
        start_rd(30);
        out_en_n = 1; #1;
        chk(rvalid === 1'b0 && rdata === '0, "R9", "oe off", 64'(rdata), 64'd0);
        out_en_n = 0; #1;
        chk(rvalid === 1'b1 && rdata === pat(30), "R9", "oe back", 64'(rdata), 64'(pat(30)));
        out_en_n = 1; adv_rd();
        chk(rvalid === 1'b0, "R9", "oe off over edge", 64'(rvalid), 64'd0);
        out_en_n = 0; #1;
        chk(rdata === pat(31), "R9", "burst advanced", 64'(rdata), 64'(pat(31)));
        dsel();

        // R10: sleep quiets output, ignores commands, keeps data
        tag = "R10";
        start_rd(32);
        sleep = 1; #1;
        chk(rvalid === 1'b0, "R10", "sleep off", 64'(rvalid), 64'd0);
        idle(); ctl_start_n = 0; all_wr_n = 0; wdata = junk; addr = 32; tick(); idle();
        sleep = 0;
        adv_rd(); chk(rvalid === 1'b0, "R10", "burst closed", 64'(rvalid), 64'd0);
        start_rd(32); chk(rdata === pat(32), "R10", "data kept", 64'(rdata), 64'(pat(32)));
        dsel(); dsel();

        // R7/R8: pipelined latency and deselect one stage later
        tag = "R7"; pipe_mode = 1;
        dsel(); dsel();
        start_rd(40); chk(rvalid === 1'b0, "R7", "not yet", 64'(rvalid), 64'd0);
        adv_rd();     chk(rvalid === 1'b1 && rdata === pat(40), "R7", "beat0", 64'(rdata), 64'(pat(40)));
        dsel();       chk(rdata === pat(41), "R8", "last beat before off", 64'(rdata), 64'(pat(41)));
        dsel();       chk(rvalid === 1'b0, "R8", "pipe off", 64'(rvalid), 64'd0);

        // random traffic in every mode/order combination
        for (int md = 0; md < 2; md++) begin
            for (int lo = 0; lo < 2; lo++) begin
                pipe_mode = md[0]; lin_order = lo[0];
                tag = md ? "R7" : "R6";
                dsel(); dsel();
                for (int n = 0; n < 1500; n++) begin
                    int r;
                    idle();
                    r = $urandom_range(99);
                    if (r < 20) host_start_n = 0;
                    else if (r < 40) ctl_start_n = 0;
                    else if (r < 45) begin host_start_n = 0; ctl_start_n = 0; end
                    r = $urandom_range(99);
                    if (r < 4) cs_a_n = 1; else if (r < 8) cs_b = 0; else if (r < 12) cs_c_n = 1;
                    r = $urandom_range(99);
                    if (r < 15) all_wr_n = 0;
                    else if (r < 45) begin bw_en_n = 0; lane_sel_n = NL'($urandom); end
                    burst_adv_n = ($urandom_range(99) < 60) ? 1'b0 : 1'b1;
                    out_en_n = ($urandom_range(99) < 8) ? 1'b1 : 1'b0;
                    sleep = ($urandom_range(99) < 3) ? 1'b1 : 1'b0;
                    addr = AW'($urandom);
                    wdata = DW'({$urandom, $urandom});
                    tick();
                end
                out_en_n = 0; sleep = 0;
                dsel(); dsel();
            end
        end
        finish_up();
    end

endmodule